// File: doc/BRIEF.md
# Interval Pulse Sequencer Core

This block plays back a stored list of timed intervals on a single output bit. Each program word pairs a one-bit output level with a duration counted in clock cycles. Once started, the core works through the words from address zero upward. It holds each level for exactly the programmed number of cycles and moves straight on to the next word, so that consecutive intervals join without a gap. With the default settings the program memory holds 1024 words, and one duration can run from 5 cycles up to 2^29 cycles.

A host loads words and the program length through a simple write port, and only while the core is idle. A duration outside the legal range is saturated to the nearest limit when it is written, and a sticky error flag records that this happened. A start pulse launches the program. After the last interval the output returns to 0 and the done flag rises. The core then ignores start until a rearm pulse or a reset brings it back to idle.

Top module: `pulse_seq_core`

## Requirements
- R1: The program memory holds 2^ADDR_W words (1024 by default). A host word write with `host_we` stores `host_level` and the duration at index `host_addr`.
- R2: A write with `host_len_we` sets the program length. A value above 2^ADDR_W is stored as 2^ADDR_W. A start while the length is 0 is ignored, and `busy` stays low.
- R3: A start sampled in idle with a nonzero length raises `busy` at the next rising edge. The level of word 0 appears on `seq_out` at the second rising edge after the start was sampled.
- R4: A written duration below MIN_DUR (5) is stored as MIN_DUR, and one above MAX_DUR (2^29 by default) is stored as MAX_DUR. Either case sets `clamp_err`. A write that is not accepted never sets it.
- R5: `clamp_err` stays high until reset. Rearm does not clear it.
- R6: Words play in address order from 0 to length-1. Each word holds its level on `seq_out` for exactly its stored duration in cycles, and the next word starts in the following cycle with no idle cycle between them.
- R7: At the edge that ends the last interval, `seq_out` goes to 0, `done` goes to 1 and `busy` goes to 0, all at once.
- R8: While `done` is high, start pulses are ignored. A rearm pulse clears `done` and returns the core to idle. A start in the same cycle as rearm does not launch a run.
- R9: Word writes and length writes are ignored while the core is running or done.
- R10: A word write and a start in the same idle cycle are both accepted, and the run that starts uses the newly written word.
- R11: After reset, `seq_out`, `busy`, `done` and `clamp_err` are 0 and the stored length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Program word write strobe |
| host_addr | input | ADDR_W | Program word index |
| host_level | input | 1 | Output level of the written word |
| host_dur | input | DUR_W | Duration of the written word in cycles |
| host_len_we | input | 1 | Program length write strobe |
| host_len | input | ADDR_W+1 | Number of words to play |
| start | input | 1 | Launch the stored program |
| rearm | input | 1 | Leave the done state and return to idle |
| seq_out | output | 1 | Sequenced output bit |
| busy | output | 1 | Program is running |
| done | output | 1 | Program has finished |
| clamp_err | output | 1 | Sticky flag for a saturated duration |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a host write to word 0 together with the start that will fetch that same word. The second pair is a rearm together with a start. The bench drives each pair on one falling edge. For the first pair, it expects the new word's level and its saturated duration in the very first interval of the run. For the second pair, it expects `busy` to stay low for the following cycles.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/pseq_prog_mem.sv
module pseq_prog_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 31,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= (we && waddr == raddr) ? wdata : mem[raddr];
  end

endmodule

// File: rtl/pseq_dur_clamp.sv
module pseq_dur_clamp #(
  parameter int DUR_W   = 30,
  parameter int MIN_DUR = 5,
  parameter int MAX_DUR = 536870912
) (
  input  logic [DUR_W-1:0] din,
  output logic [DUR_W-1:0] dout,
  output logic             too_short,
  output logic             too_long
);

  localparam logic [DUR_W-1:0] LO = DUR_W'(MIN_DUR);
  localparam logic [DUR_W-1:0] HI = DUR_W'(MAX_DUR);

  always_comb begin
    too_short = din < LO;
    too_long  = din > HI;
    if (too_short)     dout = LO;
    else if (too_long) dout = HI;
    else               dout = din;
  end

endmodule

// File: rtl/pseq_interval_timer.sv
module pseq_interval_timer #(
  parameter int DUR_W   = 30,
  parameter int MIN_DUR = 5,
  parameter int MAX_DUR = 536870912
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  output logic             expire
);

  logic [DUR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val - DUR_W'(1);
    else if (cnt != '0)    cnt <= cnt - DUR_W'(1);
  end

  assign expire = (cnt == '0);

  AST_LOAD_MIN: assert property (@(posedge clk) disable iff (rst)
    load |-> load_val >= DUR_W'(MIN_DUR)); // R4
  AST_LOAD_MAX: assert property (@(posedge clk) disable iff (rst)
    load |-> load_val <= DUR_W'(MAX_DUR)); // R4

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl import pseq_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int DUR_W  = 30,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rearm,
  input  logic [LEN_W-1:0]  len_q,
  input  logic              expire,
  input  logic              rd_level,
  input  logic [DUR_W-1:0]  rd_dur,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tmr_load,
  output logic [DUR_W-1:0]  tmr_val,
  output logic              seq_out,
  output logic              busy,
  output logic              done,
  output logic              idle
);

  seq_state_e       state, nxt;
  logic [LEN_W-1:0] ptr;
  logic [LEN_W-1:0] left;

  always_comb begin
    nxt      = state;
    rd_en    = 1'b0;
    tmr_load = 1'b0;
    case (state)
      ST_IDLE:  if (start && len_q != '0) begin
                  rd_en = 1'b1;
                  nxt   = ST_PRIME;
                end
      ST_PRIME: begin
                  tmr_load = 1'b1;
                  rd_en    = 1'b1;
                  nxt      = ST_RUN;
                end
      ST_RUN:   if (expire) begin
                  if (left == '0) nxt = ST_DONE;
                  else begin
                    tmr_load = 1'b1;
                    rd_en    = 1'b1;
                  end
                end
      default:  if (rearm) nxt = ST_IDLE;
    endcase
  end

  assign rd_addr = ptr[ADDR_W-1:0];
  assign tmr_val = rd_dur;
  assign idle    = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ptr     <= '0;
      left    <= '0;
      seq_out <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= nxt;
      if (rd_en) ptr <= ptr + LEN_W'(1);
      if (state == ST_PRIME)            left <= len_q - LEN_W'(1);
      else if (state == ST_RUN && tmr_load) left <= left - LEN_W'(1);
      if (tmr_load) seq_out <= rd_level;
      if (state == ST_IDLE && nxt == ST_PRIME) busy <= 1'b1;
      if (state == ST_RUN && nxt == ST_DONE) begin
        seq_out <= 1'b0;
        busy    <= 1'b0;
        done    <= 1'b1;
      end
      if (state == ST_DONE && nxt == ST_IDLE) begin
        done <= 1'b0;
        ptr  <= '0;
      end
    end
  end

  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !expire) |=> $stable(seq_out)); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!seq_out && !busy)); // R7
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (done && !rearm) |=> done); // R8

endmodule

// File: rtl/pulse_seq_core.sv
module pulse_seq_core #(
  parameter int ADDR_W  = 10,
  parameter int MIN_DUR = 5,
  parameter int MAX_DUR = 536870912,
  localparam int DUR_W  = $clog2(MAX_DUR + 1),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_level,
  input  logic [DUR_W-1:0]  host_dur,
  input  logic              host_len_we,
  input  logic [LEN_W-1:0]  host_len,
  input  logic              start,
  input  logic              rearm,
  output logic              seq_out,
  output logic              busy,
  output logic              done,
  output logic              clamp_err
);

  localparam int DATA_W = DUR_W + 1;
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(1 << ADDR_W);

  logic              idle;
  logic              wr_ok;
  logic [DUR_W-1:0]  dur_sat;
  logic              too_short, too_long;
  logic [LEN_W-1:0]  len_q;
  logic              rd_en, tmr_load, expire;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_word;
  logic [DUR_W-1:0]  tmr_val;

  assign wr_ok = host_we & idle;

  pseq_dur_clamp #(.DUR_W(DUR_W), .MIN_DUR(MIN_DUR), .MAX_DUR(MAX_DUR)) u_clamp (
    .din(host_dur), .dout(dur_sat), .too_short(too_short), .too_long(too_long)
  );

  pseq_prog_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(wr_ok), .waddr(host_addr), .wdata({host_level, dur_sat}),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      clamp_err <= 1'b0;
    end else begin
      if (host_len_we && idle) len_q <= (host_len > DEPTH_L) ? DEPTH_L : host_len;
      if (wr_ok && (too_short || too_long)) clamp_err <= 1'b1;
    end
  end

  pseq_interval_timer #(.DUR_W(DUR_W), .MIN_DUR(MIN_DUR), .MAX_DUR(MAX_DUR)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(expire)
  );

  pseq_ctrl #(.ADDR_W(ADDR_W), .DUR_W(DUR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .rearm(rearm), .len_q(len_q),
    .expire(expire), .rd_level(rd_word[DATA_W-1]), .rd_dur(rd_word[DUR_W-1:0]),
    .rd_en(rd_en), .rd_addr(rd_addr), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .seq_out(seq_out), .busy(busy), .done(done), .idle(idle)
  );

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    clamp_err |=> clamp_err); // R5
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!idle && host_len_we) |=> $stable(len_q)); // R9
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R7

endmodule

// File: tb/pulse_seq_core_bench.sv
module pulse_seq_core_bench;

  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int MIND = 5;
  localparam int MAXD = 64;
  localparam int DW = $clog2(MAXD + 1);
  localparam int LW = AW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0, host_level = 1'b0, host_len_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_dur = '0;
  logic [LW-1:0] host_len = '0;
  logic start = 1'b0, rearm = 1'b0;
  logic seq_out, busy, done, clamp_err;

  int checks = 0;
  int errors = 0;
  int mlvl [DEPTH];
  int mdur [DEPTH];
  int mlen = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pulse_seq_core #(.ADDR_W(AW), .MIN_DUR(MIND), .MAX_DUR(MAXD)) u_pulse_seq_core (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_level(host_level), .host_dur(host_dur), .host_len_we(host_len_we),
    .host_len(host_len), .start(start), .rearm(rearm), .seq_out(seq_out),
    .busy(busy), .done(done), .clamp_err(clamp_err)
  );

  function automatic int clampd(int v);
    return (v < MIND) ? MIND : ((v > MAXD) ? MAXD : v);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_word(int a, int l, int d, bit accept);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a); host_level = l[0]; host_dur = DW'(d);
    @(negedge clk);
    host_we = 1'b0;
    if (accept) begin mlvl[a] = l; mdur[a] = clampd(d); end
  endtask

  task automatic wr_len(int v, bit accept);
    @(negedge clk);
    host_len_we = 1'b1; host_len = LW'(v);
    @(negedge clk);
    host_len_we = 1'b0;
    if (accept) mlen = (v > DEPTH) ? DEPTH : v;
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    chk(done == 1'b0, "R8 rearm clears done", done, 0);
  endtask

  task automatic run_check(bit sim_wr, int sl, int sd, bit busy_wr);
    int total;
    @(negedge clk);
    start = 1'b1;
    if (sim_wr) begin
      host_we = 1'b1; host_addr = '0; host_level = sl[0]; host_dur = DW'(sd);
      mlvl[0] = sl; mdur[0] = clampd(sd);
    end
    @(negedge clk);
    start = 1'b0; host_we = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    total = 0;
    for (int i = 0; i < mlen; i++) total += mdur[i];
    for (int t = 0; t <= total; t++) begin
      int acc, exp;
      @(negedge clk);
      if (busy_wr && t == 2) begin
        host_we = 1'b1; host_addr = AW'(1); host_level = ~mlvl[1][0]; host_dur = DW'(1);
        host_len_we = 1'b1; host_len = LW'(1);
      end
      if (busy_wr && t == 3) begin host_we = 1'b0; host_len_we = 1'b0; end
      acc = 0; exp = 0;
      for (int i = 0; i < mlen; i++) begin
        if (t >= acc && t < acc + mdur[i]) exp = mlvl[i];
        acc += mdur[i];
      end
      if (t < total) begin
        chk(seq_out == exp[0], (t == 0) ? "R3 first level" : "R6 interval level", seq_out, exp);
        chk(busy && !done, "R6 busy during run", {busy, done}, 2);
      end else begin
        chk(seq_out == 1'b0, "R7 output low at end", seq_out, 0);
        chk(done == 1'b1 && busy == 1'b0, "R7 done at end", {busy, done}, 1);
      end
    end
    host_we = 1'b0; host_len_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!seq_out && !busy && !done && !clamp_err, "R11 reset state",
        {seq_out, busy, done, clamp_err}, 0);

    // R2: start with zero length is ignored
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R2 zero length start", {busy, done}, 0);

    // R1 R6 R7: basic three-word program
    wr_word(0, 1, 5, 1'b1);
    wr_word(1, 0, 7, 1'b1);
    wr_word(2, 1, 6, 1'b1);
    wr_len(3, 1'b1);
    run_check(1'b0, 0, 0, 1'b0);

    // R8: start ignored while done; R9: write ignored while done
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) begin
      @(negedge clk);
      chk(done && !busy && !seq_out, "R8 start ignored while done", {seq_out, busy, done}, 1);
    end
    wr_word(0, 0, 20, 1'b0);

    // R8: rearm and start in the same cycle
    @(negedge clk); rearm = 1'b1; start = 1'b1;
    @(negedge clk); rearm = 1'b0; start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !done, "R8 start with rearm ignored", {busy, done}, 0);
    end

    // R9: old word 0 still in use; writes during the run are dropped
    run_check(1'b0, 0, 0, 1'b1);
    do_rearm();
    run_check(1'b0, 0, 0, 1'b0);
    chk(clamp_err == 1'b0, "R4 no flag from dropped write", clamp_err, 0);
    do_rearm();

    // R1 R6: sweep over every program length
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++)
        wr_word(i, ((i + n) % 2) ^ (i > 2 ? 1 : 0), 5 + ((i * 3 + n) % 9), 1'b1);
      wr_len(n, 1'b1);
      run_check(1'b0, 0, 0, 1'b0);
      do_rearm();
    end

    // R2: length above depth saturates
    wr_len(15, 1'b1);
    run_check(1'b0, 0, 0, 1'b0);
    do_rearm();

    // R4: short duration clamps to minimum
    wr_word(0, 1, 2, 1'b1);
    @(negedge clk);
    chk(clamp_err == 1'b1, "R4 short duration flag", clamp_err, 1);
    wr_len(1, 1'b1);
    run_check(1'b0, 0, 0, 1'b0);
    do_rearm();

    // R4: long duration clamps to maximum
    wr_word(0, 1, 100, 1'b1);
    run_check(1'b0, 0, 0, 1'b0);
    do_rearm();

    // R10: word write together with start
    wr_word(1, 1, 8, 1'b1);
    wr_len(2, 1'b1);
    run_check(1'b1, 0, 3, 1'b0);
    do_rearm();
    run_check(1'b1, 1, 9, 1'b0);
    do_rearm();

    // R5: flag survives rearm, cleared by reset
    chk(clamp_err == 1'b1, "R5 flag sticky across rearm", clamp_err, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(clamp_err == 1'b0 && !busy && !done, "R5 reset clears flag", clamp_err, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 length zero after reset", busy, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule